// File: doc/BRIEF.md
# Clocked 8-bit Serial Shift Unit

The unit moves one byte at a time over a synchronous serial link. Software loads the data register, chooses a shift-clock source and a bit order in the control register, and sets the start bit. On every falling edge of the shift clock the next outgoing bit goes onto the serial output. On every rising edge the serial input is sampled into the vacated end of the data register. After eight rising edges the byte that was sent has been replaced by the byte that was received, the busy bit drops and the complete flag is set.

The shift clock comes from one of two sources. It can be generated internally from the system clock at one of three rates, and it can then be driven out to a peer. It can also be taken from an external clock pin, which lets the unit act as the receiving side of a link that a peer drives. With the external clock the unit waits after start until edges arrive. Those edges pass through a two-flop synchronizer and an edge detector before they act.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset, both registers read 0x00, the shift-clock output is high, the serial output is high, both output enables are low and the interrupt request is low.
- R2: Address 0 holds the control register and address 1 the data register. The control register bits are: bit 7 complete flag, bit 6 interrupt enable, bit 5 clock output enable, bit 4 data output enable, bits 3:2 rate code, bit 1 order (1 = LSB first), bit 0 start/busy. Writing 1 to bit 0 while idle starts a transfer, and bit 0 reads 1 until the transfer ends. A start write made during a transfer has no effect.
- R3: Rate codes 00, 01 and 10 give an internal shift clock of the system clock divided by 2, 8 and 32. A transfer therefore takes 16, 64 and 256 cycles from the start write to the complete flag, with exactly 8 low pulses on the clock.
- R4: The shift-clock output idles high. Its enable equals bit 5 while the rate code is not 11, and is low when the code is 11.
- R5: On each rising shift-clock edge the serial input enters the data register: at bit 0 with a left shift when MSB first, at bit 7 with a right shift when LSB first.
- R6: The serial output changes only on a falling shift-clock edge. It then takes bit 7 of the data register (MSB first) or bit 0 (LSB first).
- R7: Rate code 11 takes the shift clock from the external pin through a two-flop synchronizer. Edges on that pin while no transfer runs change nothing.
- R8: On the eighth rising edge, the busy bit clears and the complete flag sets on the same clock edge.
- R9: The interrupt request is high exactly while the complete flag and the interrupt enable are both 1.
- R10: Writing 0 to bit 7 clears the flag and writing 1 leaves it unchanged. If a clearing write falls on the completion edge, the flag ends up set.
- R11: During a transfer, writes to the data register and to control bits 5..1 are ignored. Bit 6 stays writable.
- R12: The serial-output enable equals control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output |
| ser_out_en | output | 1 | Enable for the serial output driver |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Internally generated shift clock |
| sck_out_en | output | 1 | Enable for the shift-clock driver |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
The risky overlap is the completion edge, which sets the flag, landing in the same cycle as a software write that clears it. The bench drives the external clock by hand, so it knows that the last rising edge reaches the register three clock edges after the pin moves. It places a clearing control write on exactly that edge and requires the flag to read back as set. A second overlap, writes made while busy, is provoked with data and control writes between start and the first edge. The reads that follow must show that only the interrupt enable changed.

// File: rtl/sio_pkg.sv
// Shared definitions for the serial shift unit: control-register layout,
// rate code for the external clock and register addresses.
package sio_pkg;

    // Control register, bit 7 first; the layout is visible to software.
    typedef struct packed {
        logic       done;       // transfer complete flag
        logic       irq_en;     // interrupt enable
        logic       clk_oe;     // drive shift clock out
        logic       dat_oe;     // drive serial data out
        logic [1:0] rate;       // shift clock source / rate
        logic       lsb_first;  // bit order
        logic       busy;       // start / in progress
    } sio_ctrl_t;

    localparam logic [1:0] RATE_EXT  = 2'b11;
    localparam logic       ADDR_CTRL = 1'b0;
    localparam logic       ADDR_DATA = 1'b1;

endpackage

// File: rtl/sio_rate_gen.sv
// Internal shift-clock generator. While run is high it toggles sck every
// half period of the selected divider and flags each toggle as a falling or
// rising strobe in the cycle the toggle is registered. While run is low it
// holds sck high and its counter at zero.
// Assumes every divider is even and at least 2.
module sio_rate_gen #(
    parameter int DIV0 = 2,
    parameter int DIV1 = 8,
    parameter int DIV2 = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       sck,
    output logic       fall_stb,
    output logic       rise_stb
);
    localparam int MAXDIV = (DIV0 > DIV1) ? ((DIV0 > DIV2) ? DIV0 : DIV2)
                                          : ((DIV1 > DIV2) ? DIV1 : DIV2);
    localparam int CW     = (MAXDIV / 2 > 1) ? $clog2(MAXDIV / 2) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;
    logic          tick;

    // Pick the last count of a half period for the current rate code.
    always_comb begin
        case (rate)
            2'b00:   half_m1 = CW'(DIV0 / 2 - 1);
            2'b01:   half_m1 = CW'(DIV1 / 2 - 1);
            default: half_m1 = CW'(DIV2 / 2 - 1);
        endcase
    end

    // Toggle strobes, split by the level sck is leaving.
    always_comb begin
        tick     = run && (cnt == half_m1);
        fall_stb = tick && sck;
        rise_stb = tick && !sck;
    end

    // Half-period counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (tick) begin
            cnt <= '0;
            sck <= !sck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sio_ext_edge.sv
// Synchronizes the external shift clock into the system clock domain and
// gives one-cycle strobes for its rising and falling edges. The chain resets
// high to match an idle-high clock, so reset creates no false edge.
// Assumes the external clock is slower than a quarter of the system clock.
module sio_ext_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise_stb,
    output logic fall_stb
);
    // taps[STAGES-1] is the synchronized level, taps[STAGES] its previous value
    logic [STAGES:0] taps;

    // Shift the pin through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) taps <= '1;
        else        taps <= {taps[STAGES-1:0], pin};
    end

    // Edge strobes from the synchronized level and its history.
    always_comb begin
        rise_stb = taps[STAGES-1] && !taps[STAGES];
        fall_stb = !taps[STAGES-1] && taps[STAGES];
    end

endmodule

// File: rtl/sio_shift_core.sv
// Data path of a transfer: the data register, the registered output bit and
// the bit counter. Falling strobes present the next outgoing bit, and rising
// strobes sample the input and count. done pulses with the last rising strobe.
// Assumes the top only loads when idle and only strobes when busy.
module sio_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         start,
    input  logic         lsb_first,
    input  logic         sin,
    input  logic         fall_stb,
    input  logic         rise_stb,
    output logic [W-1:0] data,
    output logic         sout,
    output logic         done
);
    localparam int CNT_W = (W > 2) ? $clog2(W) : 1;

    logic [CNT_W-1:0] bit_cnt;

    // Data register: software load or one shift per rising strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        data <= '0;
        else if (load)     data <= load_val;
        else if (rise_stb) data <= lsb_first ? {sin, data[W-1:1]}
                                             : {data[W-2:0], sin};
    end

    // Output bit: updated only on falling strobes, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n)        sout <= 1'b1;
        else if (fall_stb) sout <= lsb_first ? data[0] : data[W-1];
    end

    // Bit counter: cleared at start, advanced per sampled bit.
    always_ff @(posedge clk) begin
        if (!rst_n || start) bit_cnt <= '0;
        else if (rise_stb)   bit_cnt <= bit_cnt + 1'b1;
    end

    // Last bit sampled.
    always_comb done = rise_stb && (bit_cnt == CNT_W'(W - 1));

endmodule

// File: rtl/serial_shift_unit.sv
// Top of the serial shift unit: control register, register bus, selection
// between the internal and external shift clock, and the output pins.
// Assumes DATA_W >= 8 so that the control word fits on the bus.
module serial_shift_unit
    import sio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV0        = 2,
    parameter int DIV1        = 8,
    parameter int DIV2        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ser_in,
    output logic              ser_out,
    output logic              ser_out_en,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_out_en,
    output logic              irq
);
    sio_ctrl_t         ctrl_q;
    sio_ctrl_t         wr_fields;
    logic [7:0]        ctrl_word;
    logic              busy, flag, ext_mode;
    logic              wr_ctrl, wr_data, start_go;
    logic              int_sck, int_fall, int_rise;
    logic              ext_fall, ext_rise;
    logic              fall_evt, rise_evt, xfer_done;
    logic [DATA_W-1:0] data_q;

    // Decode bus writes and split the shift-clock source.
    always_comb begin
        wr_fields = sio_ctrl_t'(bus_wdata[7:0]);
        busy      = ctrl_q.busy;
        flag      = ctrl_q.done;
        ext_mode  = (ctrl_q.rate == RATE_EXT);
        wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
        wr_data   = bus_wr && (bus_addr == ADDR_DATA) && !busy;
        start_go  = wr_ctrl && !busy && wr_fields.busy;
        fall_evt  = busy && (ext_mode ? ext_fall : int_fall);
        rise_evt  = busy && (ext_mode ? ext_rise : int_rise);
    end

    sio_rate_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy && !ext_mode),
        .rate     (ctrl_q.rate),
        .sck      (int_sck),
        .fall_stb (int_fall),
        .rise_stb (int_rise)
    );

    sio_ext_edge #(.STAGES(SYNC_STAGES)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (sck_in),
        .rise_stb (ext_rise),
        .fall_stb (ext_fall)
    );

    sio_shift_core #(.W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_data),
        .load_val  (bus_wdata),
        .start     (start_go),
        .lsb_first (ctrl_q.lsb_first),
        .sin       (ser_in),
        .fall_stb  (fall_evt),
        .rise_stb  (rise_evt),
        .data      (data_q),
        .sout      (ser_out),
        .done      (xfer_done)
    );

    // Control register: locked fields while busy, completion wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.irq_en <= wr_fields.irq_en;
                if (!busy) begin
                    ctrl_q.clk_oe    <= wr_fields.clk_oe;
                    ctrl_q.dat_oe    <= wr_fields.dat_oe;
                    ctrl_q.rate      <= wr_fields.rate;
                    ctrl_q.lsb_first <= wr_fields.lsb_first;
                end
            end
            if (start_go)       ctrl_q.busy <= 1'b1;
            else if (xfer_done) ctrl_q.busy <= 1'b0;
            if (xfer_done)                        ctrl_q.done <= 1'b1;
            else if (wr_ctrl && !wr_fields.done)  ctrl_q.done <= 1'b0;
        end
    end

    // Read mux and pin outputs.
    always_comb begin
        ctrl_word  = ctrl_q;
        bus_rdata  = (bus_addr == ADDR_DATA) ? data_q : DATA_W'(ctrl_word);
        sck_out    = int_sck;
        sck_out_en = ctrl_q.clk_oe && !ext_mode;
        ser_out_en = ctrl_q.dat_oe;
        irq        = ctrl_q.done && ctrl_q.irq_en;
    end

endmodule

// File: rtl/sio_checker.sv
// Temporal properties of the serial shift unit, bound to every instance.
module sio_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              flag,
    input logic              sck_out,
    input logic              ser_out,
    input logic              fall_evt,
    input logic              rise_evt,
    input logic [DATA_W-1:0] data_q,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic              wdata_top
);
    // R4
    sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out);

    // R8
    done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> flag);

    // R6
    sout_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_evt |=> $stable(ser_out));

    // R11
    data_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rise_evt) |=> $stable(data_q));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(bus_wr && !bus_addr && !wdata_top)) |=> flag);

    // R2
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rise_evt) |=> busy);

endmodule

bind serial_shift_unit sio_checker #(.DATA_W(DATA_W)) u_sio_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .flag      (flag),
    .sck_out   (sck_out),
    .ser_out   (ser_out),
    .fall_evt  (fall_evt),
    .rise_evt  (rise_evt),
    .data_q    (data_q),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wdata_top (bus_wdata[7])
);

// File: tb/sim_serial_shift_unit.sv
// Bench for serial_shift_unit: a behavioural per-cycle model compared on
// every clock, plus directed checks of rates, bit order and flag races.
module sim_serial_shift_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ser_in, ser_out, ser_out_en;
    logic       sck_in, sck_out, sck_out_en, irq;
    logic       lb = 1'b0;
    logic       ser_drv = 1'b1;
    logic       sck_drv = 1'b1;
    int         vectors = 0;
    int         fails = 0;

    always #5 clk = !clk;
    assign ser_in = lb ? ser_out : ser_drv;
    assign sck_in = sck_drv;

    serial_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_in(ser_in),
        .ser_out(ser_out), .ser_out_en(ser_out_en), .sck_in(sck_in),
        .sck_out(sck_out), .sck_out_en(sck_out_en), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    bit       m_ok = 0;
    bit       m_flag, m_ie, m_sce, m_soe, m_lsb, m_busy, m_out, m_sck;
    bit [1:0] m_rate;
    bit [7:0] m_data;
    int       m_cnt, m_bits;
    bit       h1, h2, h3;

    always @(posedge clk) begin
        bit busy_old, e_rise, e_fall, i_rise, i_fall, rise, fall, done, ext;
        int half;
        if (!rst_n) begin
            {m_flag, m_ie, m_sce, m_soe, m_lsb, m_busy} = '0;
            m_rate = 0; m_data = 0; m_out = 1; m_sck = 1;
            m_cnt = 0; m_bits = 0; h1 = 1; h2 = 1; h3 = 1; m_ok = 1;
        end else begin
            busy_old = m_busy;
            e_rise = h2 && !h3;
            e_fall = !h2 && h3;
            h3 = h2; h2 = h1; h1 = sck_in;
            ext  = (m_rate == 2'b11);
            half = (m_rate == 0) ? 1 : (m_rate == 1) ? 4 : 16;
            i_rise = 0; i_fall = 0;
            if (m_busy && !ext) begin
                if (m_cnt == half - 1) begin
                    if (m_sck) i_fall = 1; else i_rise = 1;
                    m_cnt = 0; m_sck = !m_sck;
                end else m_cnt++;
            end else begin
                m_cnt = 0; m_sck = 1;
            end
            rise = m_busy && (ext ? e_rise : i_rise);
            fall = m_busy && (ext ? e_fall : i_fall);
            done = 0;
            if (fall) m_out = m_lsb ? m_data[0] : m_data[7];
            if (rise) begin
                m_data = m_lsb ? {ser_in, m_data[7:1]} : {m_data[6:0], ser_in};
                m_bits++;
                if (m_bits == 8) done = 1;
            end
            if (bus_wr && bus_addr && !busy_old) m_data = bus_wdata;
            if (bus_wr && !bus_addr) begin
                m_ie = bus_wdata[6];
                if (!busy_old) begin
                    m_sce = bus_wdata[5]; m_soe = bus_wdata[4];
                    m_rate = bus_wdata[3:2]; m_lsb = bus_wdata[1];
                    if (bus_wdata[0]) begin m_busy = 1; m_bits = 0; end
                end
            end
            if (done) begin m_busy = 0; m_flag = 1; end
            else if (bus_wr && !bus_addr && !bus_wdata[7]) m_flag = 0;
        end
    end

    // Per-cycle comparison, away from the clock edge.
    always @(posedge clk) begin
        #2;
        if (m_ok) begin
            chk("R3 sck_out", sck_out, m_sck);
            chk("R4 sck_out_en", sck_out_en, m_sce && (m_rate != 2'b11));
            chk("R6 ser_out", ser_out, m_out);
            chk("R12 ser_out_en", ser_out_en, m_soe);
            chk("R9 irq", irq, m_flag && m_ie);
            chk("R2 rdata", bus_rdata, bus_addr ? m_data
                : {m_flag, m_ie, m_sce, m_soe, m_rate, m_lsb, m_busy});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done(output int cycles);
        bus_addr = 0;
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
            #1;
        end while (!bus_rdata[7] && cycles < 1000);
    endtask

    task automatic ext_xfer(input logic [7:0] tx, input bit lsb, input bit collide,
                            output logic [7:0] cap);
        for (int i = 0; i < 8; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            @(negedge clk) sck_drv = 0;
            repeat (4) @(negedge clk);
            cap[idx] = ser_out;
            ser_drv = tx[idx];
            sck_drv = 1;
            if (collide && i == 7) begin
                // the last rising edge acts on the third clock edge from here
                @(negedge clk);
                @(negedge clk);
                bus_wr = 1; bus_addr = 0; bus_wdata = 8'h40;
                @(negedge clk);
                bus_wr = 0;
                repeat (2) @(negedge clk);
            end else begin
                repeat (4) @(negedge clk);
            end
        end
    endtask

    // ---------------- directed sequence ----------------
    task automatic run_tests;
        logic [7:0] r, cap;
        int         cyc;
        logic [7:0] pats [3] = '{8'h96, 8'h3C, 8'hE1};
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd(0, r); chk("R1 ctrl after reset", r, 8'h00);
        rd(1, r); chk("R1 data after reset", r, 8'h00);
        chk("R1 sck_out idle", sck_out, 1);
        chk("R1 ser_out idle", ser_out, 1);
        chk("R1 irq", irq, 0);
        chk("R1 sck_out_en", sck_out_en, 0);

        wr(0, 8'h30);
        chk("R4 clock enable internal", sck_out_en, 1);
        chk("R12 data enable", ser_out_en, 1);
        chk("R4 idle high", sck_out, 1);
        wr(0, 8'h3C);
        chk("R4 clock enable external", sck_out_en, 0);
        wr(0, 8'h20);
        chk("R12 data enable off", ser_out_en, 0);

        // internal clock, loopback, each rate, alternating order
        lb = 1;
        for (int k = 0; k < 3; k++) begin
            int h;
            h = (k == 0) ? 1 : (k == 1) ? 4 : 16;
            wr(1, pats[k]);
            wr(0, {1'b0, 1'b1, 1'b1, 1'b1, 2'(k), 1'(k % 2), 1'b1});
            wait_done(cyc);
            chk("R3 cycles to complete", cyc, 16 * h);
            rd(0, r);
            chk("R8 busy clear, flag set", {r[7], r[0]}, 2'b10);
            chk("R9 irq with enable", irq, 1);
            rd(1, r);
            chk("R5 loopback data", r, pats[k]);
        end
        lb = 0;

        // flag write rules
        wr(0, 8'hF0);
        rd(0, r); chk("R10 write 1 keeps flag", r[7], 1);
        wr(0, 8'h70);
        rd(0, r); chk("R10 write 0 clears flag", r[7], 0);
        chk("R9 irq low after clear", irq, 0);

        // external mode, idle edges ignored
        wr(0, 8'h1C);
        wr(1, 8'h5A);
        for (int t = 0; t < 3; t++) begin
            @(negedge clk) sck_drv = 0; ser_drv = 0;
            repeat (5) @(negedge clk);
            sck_drv = 1;
            repeat (5) @(negedge clk);
        end
        rd(1, r); chk("R7 idle edges keep data", r, 8'h5A);
        rd(0, r); chk("R7 idle edges keep ctrl", r, 8'h1C);
        chk("R7 idle edges keep ser_out", ser_out, 1);

        // external transfer, MSB first, writes during busy, flag race
        wr(1, 8'hC3);
        wr(0, 8'h1D);
        wr(1, 8'hFF);
        wr(0, 8'h47);
        rd(0, r); chk("R11 only irq enable changes while busy", r, 8'h5D);
        rd(1, r); chk("R11 data write ignored while busy", r, 8'hC3);
        wr(0, 8'h5D);
        rd(0, r); chk("R2 start while busy ignored", r, 8'h5D);
        ext_xfer(8'h6A, 0, 1, cap);
        rd(0, r); chk("R10 completion beats clear", r, 8'hDC);
        chk("R9 irq after race", irq, 1);
        rd(1, r); chk("R7 received byte MSB first", r, 8'h6A);
        chk("R6 sent bits MSB first", cap, 8'hC3);

        // external transfer, LSB first, interrupt disabled
        wr(1, 8'h81);
        wr(0, 8'h1F);
        ext_xfer(8'h2D, 1, 0, cap);
        rd(0, r); chk("R8 ctrl after LSB transfer", r, 8'h9E);
        chk("R9 irq masked", irq, 0);
        rd(1, r); chk("R5 received byte LSB first", r, 8'h2D);
        chk("R6 sent bits LSB first", cap, 8'h81);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule